// File: doc/BRIEF.md
# Per-Port Event Counter Bank with Snapshot Byte Reads

This block holds one 16-bit event counter for each port. A port's counter goes up by one on every clock in which that port raises its event strobe while its enable bit is set. Two control bits per port shape the counting. One makes the counter saturate at its maximum instead of rolling over. The other makes the counter clear each time software reads it.

Software reads the counters one byte at a time through a synchronous read port. A read gives a counter index and a byte select. The first byte of a pair copies the whole 16-bit value into one holding register that all ports share. The other byte of that counter is then served from the copy, so the two halves always belong to the same count. Software may read the two bytes in either order. Events that arrive between the two reads are still counted in the live counter, but they do not tear the pair.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset, every counter is 0, `rd_data_o` is 0 and no snapshot is valid, so the first read takes a snapshot.
- R2: When `evt_i[p]` and `evt_en_i[p]` are both 1 in a cycle, counter p goes up by exactly one at that clock edge.
- R3: When `evt_i[p]` is 1 but `evt_en_i[p]` is 0, counter p does not change.
- R4: When `sat_en_i[p]` is 0, an enabled event on a counter at 0xFFFF sets it to 0x0000.
- R5: When `sat_en_i[p]` is 1, an enabled event on a counter at 0xFFFF leaves it at 0xFFFF.
- R6: A read is a cycle with `rd_en_i`=1. Its byte appears on `rd_data_o` after the next clock edge. `rd_hi_i`=1 selects bits 15:8 and `rd_hi_i`=0 selects bits 7:0. Without a read, `rd_data_o` keeps its value.
- R7: A read takes a snapshot when no snapshot is valid. It copies the counter's live value, as it stood before that edge, into the holding register and returns the requested byte of that value.
- R8: A read of the other byte of the counter that holds the snapshot returns that byte from the holding register, whatever events occurred since. It then marks the snapshot invalid.
- R9: A read of a different counter, or of the same byte of the same counter again, takes a new snapshot.
- R10: After a pair has completed, the next read of any counter or byte takes a fresh snapshot.
- R11: When `clr_on_rd_i[p]` is 1, a snapshot of counter p sets the counter to 0, or to 1 if an enabled event on p arrives in the same cycle. A read served from the holding register does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_PORTS | Per-port event strobe, one cycle per event |
| evt_en_i | input | N_PORTS | Per-port event enable |
| clr_on_rd_i | input | N_PORTS | Per-port clear-on-read control |
| sat_en_i | input | N_PORTS | Per-port saturation control |
| rd_en_i | input | 1 | Byte read strobe |
| rd_idx_i | input | IDX_W | Counter index of the read |
| rd_hi_i | input | 1 | Byte select: 1 selects the high byte, 0 the low byte |
| rd_data_o | output | DATA_W | Byte returned by the last read |

## Verification
The hardest cases to reach are the counter boundaries. Wrap and saturation only show up after 65,535 events. The stimulus therefore holds the strobes high on two ports for more than 65,536 cycles, one port with saturation set and one without, and then reads both bytes of each. Torn reads are the other hard case. The bench snapshots a counter whose value sits just below a byte boundary, pushes it across that boundary with further events, and then reads the other byte. It also reads a clear-on-read port in the same cycle as an event, and runs long stretches of random reads, events and controls against a cycle-level model.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/evt_cnt_cell.sv
module evt_cnt_cell
  import evt_cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  input  logic sat_i,
  output cnt_t cnt_o
);
  localparam cnt_t CNT_MAX = '1;

  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      // an event coinciding with the clear is kept
      cnt_q <= inc_i ? cnt_t'(1) : '0;
    end else if (inc_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + cnt_t'(1);
      else if (!sat_i)      cnt_q <= '0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_cnt_snap.sv
module evt_cnt_snap
  import evt_cnt_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_hi_i,
  input  cnt_t             live_i,
  output logic             take_o,
  output cnt_t             hold_o,
  output logic             vld_o,
  output byte_t            rd_data_o
);
  cnt_t             hold_q;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic             hi_q;
  byte_t            data_q;

  // new snapshot unless this read completes the open pair
  assign take_o = rd_en_i && (!vld_q || (rd_idx_i != idx_q) || (rd_hi_i == hi_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      hi_q   <= 1'b0;
      data_q <= '0;
    end else if (take_o) begin
      hold_q <= live_i;
      vld_q  <= 1'b1;
      idx_q  <= rd_idx_i;
      hi_q   <= rd_hi_i;
      data_q <= rd_hi_i ? live_i[CNT_W-1:DATA_W] : live_i[DATA_W-1:0];
    end else if (rd_en_i) begin
      vld_q  <= 1'b0;
      data_q <= rd_hi_i ? hold_q[CNT_W-1:DATA_W] : hold_q[DATA_W-1:0];
    end
  end

  assign hold_o    = hold_q;
  assign vld_o     = vld_q;
  assign rd_data_o = data_q;
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] evt_i,
  input  logic [N_PORTS-1:0] evt_en_i,
  input  logic [N_PORTS-1:0] clr_on_rd_i,
  input  logic [N_PORTS-1:0] sat_en_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic               rd_hi_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  cnt_t                   cnt_arr [N_PORTS];
  logic [N_PORTS*CNT_W-1:0] cnt_flat;
  logic [N_PORTS-1:0]     clr_vec;
  cnt_t                   live_w;
  cnt_t                   hold_w;
  logic                   take_w;
  logic                   snap_vld;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign clr_vec[p] = take_w && clr_on_rd_i[p] && (rd_idx_i == IDX_W'(p));

    evt_cnt_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (evt_i[p] && evt_en_i[p]),
      .clr_i (clr_vec[p]),
      .sat_i (sat_en_i[p]),
      .cnt_o (cnt_arr[p])
    );

    assign cnt_flat[p*CNT_W +: CNT_W] = cnt_arr[p];
  end

  always_comb begin
    live_w = '0;
    for (int unsigned p = 0; p < N_PORTS; p++) begin
      if (rd_idx_i == IDX_W'(p)) live_w = cnt_arr[p];
    end
  end

  evt_cnt_snap #(.IDX_W(IDX_W)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .rd_idx_i (rd_idx_i),
    .rd_hi_i  (rd_hi_i),
    .live_i   (live_w),
    .take_o   (take_w),
    .hold_o   (hold_w),
    .vld_o    (snap_vld),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk
  import evt_cnt_pkg::*;
#(
  parameter int unsigned N_PORTS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_PORTS-1:0]       evt_i,
  input logic [N_PORTS-1:0]       evt_en_i,
  input logic [N_PORTS-1:0]       sat_en_i,
  input logic [N_PORTS-1:0]       clr_vec,
  input logic                     rd_en_i,
  input logic                     rd_hi_i,
  input logic                     take_w,
  input logic                     snap_vld,
  input cnt_t                     live_w,
  input cnt_t                     hold_w,
  input logic [N_PORTS*CNT_W-1:0] cnt_flat,
  input byte_t                    rd_data_o
);
  AST_PAIR_FROM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !take_w |=> rd_data_o == ($past(rd_hi_i) ? $past(hold_w[CNT_W-1:DATA_W])
                                                        : $past(hold_w[DATA_W-1:0]))); // R8
  AST_PAIR_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !take_w |=> !snap_vld); // R10
  AST_SNAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w |=> snap_vld && hold_w == $past(live_w)); // R7
  AST_IDLE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R6

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[p] && evt_en_i[p] && !clr_vec[p] && cnt_flat[p*CNT_W +: CNT_W] != '1
      |=> cnt_flat[p*CNT_W +: CNT_W] == $past(cnt_flat[p*CNT_W +: CNT_W]) + cnt_t'(1)); // R2
    AST_MASKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(evt_i[p] && evt_en_i[p]) && !clr_vec[p] |=> $stable(cnt_flat[p*CNT_W +: CNT_W])); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sat_en_i[p] && !clr_vec[p] && cnt_flat[p*CNT_W +: CNT_W] == '1
      |=> cnt_flat[p*CNT_W +: CNT_W] == '1); // R5
    AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[p] && evt_en_i[p] && !sat_en_i[p] && !clr_vec[p] && cnt_flat[p*CNT_W +: CNT_W] == '1
      |=> cnt_flat[p*CNT_W +: CNT_W] == '0); // R4
    AST_CLR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vec[p] |=> cnt_flat[p*CNT_W +: CNT_W] == cnt_t'($past(evt_i[p] && evt_en_i[p]))); // R11
  end
endmodule

bind evt_cnt_bank evt_cnt_bank_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .evt_en_i (evt_en_i),
  .sat_en_i (sat_en_i),
  .clr_vec  (clr_vec),
  .rd_en_i  (rd_en_i),
  .rd_hi_i  (rd_hi_i),
  .take_w   (take_w),
  .snap_vld (snap_vld),
  .live_w   (live_w),
  .hold_w   (hold_w),
  .cnt_flat (cnt_flat),
  .rd_data_o(rd_data_o)
);

// File: tb/evt_cnt_bank_bench.sv
`timescale 1ns/1ps
module evt_cnt_bank_bench;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0, evt_en_i = '0, clr_on_rd_i = '0, sat_en_i = '0;
  logic         rd_en_i = 1'b0;
  logic [2:0]   rd_idx_i = '0;
  logic         rd_hi_i = 1'b0;
  logic [7:0]   rd_data_o;

  evt_cnt_bank #(.N_PORTS(N)) u_evt_cnt_bank (.*);

  always #5 clk_i = ~clk_i;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  int    m_cnt [N];
  int    m_hold = 0, m_data = 0;
  bit    m_vld = 0, m_hi = 0;
  int    m_idx = 0;
  string m_tag = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // behavioural reference, applied at each rising edge
  task automatic model_edge();
    bit clr [N];
    foreach (clr[p]) clr[p] = 0;
    if (rd_en_i) begin
      if (!m_vld || int'(rd_idx_i) != m_idx || rd_hi_i == m_hi) begin
        m_hold = m_cnt[rd_idx_i];
        m_vld  = 1; m_idx = int'(rd_idx_i); m_hi = rd_hi_i;
        m_data = rd_hi_i ? (m_hold >> 8) : (m_hold & 255);
        clr[rd_idx_i] = clr_on_rd_i[rd_idx_i];
        m_tag = "R7";
      end else begin
        m_data = rd_hi_i ? (m_hold >> 8) : (m_hold & 255);
        m_vld  = 0;
        m_tag = "R8";
      end
    end else m_tag = "R6";
    for (int p = 0; p < N; p++) begin
      if (clr[p]) m_cnt[p] = 0;
      if (evt_i[p] && evt_en_i[p]) begin
        if (m_cnt[p] == 65535) m_cnt[p] = sat_en_i[p] ? 65535 : 0;
        else m_cnt[p] = m_cnt[p] + 1;
      end
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    cyc++;
    @(negedge clk_i);
    chk(m_tag, int'(rd_data_o), m_data);
  endtask

  task automatic rd_byte(input int idx, input bit hi, input string tag);
    rd_en_i = 1; rd_idx_i = 3'(idx); rd_hi_i = hi;
    step();
    chk(tag, int'(rd_data_o), m_data);
    rd_en_i = 0;
  endtask

  task automatic pulse(input int p, input int n);
    evt_i[p] = 1;
    for (int i = 0; i < n; i++) step();
    evt_i[p] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end (got hang, expected completion)");
    finish_run();
  end

  initial begin
    foreach (m_cnt[p]) m_cnt[p] = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", int'(rd_data_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    rd_byte(0, 0, "R1");
    rd_byte(0, 1, "R1");

    // R2 count and R8 torn pair across a byte boundary
    evt_en_i[1] = 1;
    pulse(1, 250);
    rd_byte(1, 0, "R2");
    chk("R2", int'(rd_data_o), 250);
    pulse(1, 10);
    rd_byte(1, 1, "R8");
    chk("R8", int'(rd_data_o), 0);
    // R10 fresh snapshot after a pair
    rd_byte(1, 1, "R10");
    chk("R10", int'(rd_data_o), 1);
    // R9 same byte re-read
    pulse(1, 5);
    rd_byte(1, 1, "R9");
    rd_byte(1, 0, "R9");
    chk("R9", int'(rd_data_o), 265 & 255);
    // R9 different counter breaks the pair
    rd_byte(1, 0, "R9");
    rd_byte(2, 1, "R9");
    pulse(1, 3);
    rd_byte(1, 1, "R9");
    rd_byte(1, 0, "R9");
    chk("R9", int'(rd_data_o), 268 & 255);

    // R3 masked events
    evt_en_i[2] = 0;
    pulse(2, 20);
    rd_byte(2, 0, "R3");
    chk("R3", int'(rd_data_o), 0);

    // R11 clear on read with a coincident event
    evt_en_i[5] = 1; clr_on_rd_i[5] = 1;
    pulse(5, 7);
    evt_i[5] = 1;
    rd_byte(5, 0, "R11");
    evt_i[5] = 0;
    chk("R11", int'(rd_data_o), 7);
    rd_byte(5, 1, "R11");
    rd_byte(5, 0, "R11");
    chk("R11", int'(rd_data_o), 1);
    rd_byte(5, 1, "R11");
    chk("R11", int'(rd_data_o), 0);
    rd_byte(5, 0, "R11");
    chk("R11", int'(rd_data_o), 0);

    // R4 / R5 boundary: port 3 saturates, port 4 wraps
    evt_en_i[3] = 1; sat_en_i[3] = 1;
    evt_en_i[4] = 1; sat_en_i[4] = 0;
    evt_i[3] = 1; evt_i[4] = 1;
    for (int i = 0; i < 65538; i++) step();
    evt_i[3] = 0; evt_i[4] = 0;
    rd_byte(3, 1, "R5");
    chk("R5", int'(rd_data_o), 255);
    rd_byte(3, 0, "R5");
    chk("R5", int'(rd_data_o), 255);
    rd_byte(4, 0, "R4");
    chk("R4", int'(rd_data_o), 2);
    rd_byte(4, 1, "R4");
    chk("R4", int'(rd_data_o), 0);

    // random traffic, every cycle compared
    for (int ph = 0; ph < 6; ph++) begin
      evt_en_i = N'($urandom); clr_on_rd_i = N'($urandom); sat_en_i = N'($urandom);
      for (int i = 0; i < 600; i++) begin
        evt_i    = N'($urandom);
        rd_en_i  = ($urandom % 2) == 0;
        rd_idx_i = 3'($urandom % 4);
        rd_hi_i  = 1'($urandom);
        step();
      end
    end
    rd_en_i = 0; evt_i = '0;
    step();
    finish_run();
  end
endmodule